// File: doc/BRIEF.md
# Zero-Address Stack Evaluator

This block holds a small downward-growing stack of data words in a register file and executes zero-address commands against it. A command is presented with `cmdValid` while `busy` is low. The commands are:

- push a word;
- pop the top word to the output;
- add the two top entries;
- multiply the two top entries.

An arithmetic command removes both operands and leaves the result on top. A host can therefore evaluate a reverse Polish expression by streaming its tokens in order and then popping the answer.

The stack pointer starts one past the highest storage address. A push moves the pointer down and then writes the word at the new address. A pop reads the word at the pointer and then moves the pointer up. The full and empty flags are updated by comparing the pointer as it moves; there is no separate occupancy counter.

A command that would overflow or underflow the stack is refused. A refused command leaves the stack as it was and sets a sticky error flag.

Top module: `stack_eval`

## Requirements
- R1: After reset, `empty` is 1, and `full`, `errFlag`, `busy` and `outValid` are 0.
- R2: Command codes on `cmdOp` are 0 for push, 1 for pop, 2 for add and 3 for multiply. A pop accepted at a clock edge drives the top word on `dataOut` with `outValid` high for exactly the following cycle. Words come back last-in first-out.
- R3: The stack holds `DEPTH` (default 11) words. `full` rises on the push that stores the last free word and falls on the next accepted pop.
- R4: `empty` rises on the pop that removes the last word and falls on any accepted push.
- R5: An add is accepted only with at least two entries. It then holds `busy` high for exactly three cycles and replaces the two top entries with their sum, truncated to `DATA_W` bits.
- R6: A multiply follows the same rules as R5 and leaves the product, truncated to `DATA_W` bits.
- R7: A push while `full` is refused: `errFlag` is set and the stored words and flags are unchanged.
- R8: A pop with no entries, or an add or multiply with fewer than two, is refused. `errFlag` is set, no output is produced, `busy` stays low and the stored words are unchanged.
- R9: While `busy` is high, `cmdValid` is ignored.
- R10: Once set, `errFlag` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken when busy is low |
| cmdOp | input | 2 | Command code (0 push, 1 pop, 2 add, 3 multiply) |
| cmdData | input | DATA_W | Word to push |
| busy | output | 1 | High while an add or multiply is in progress |
| dataOut | output | DATA_W | Word removed by the last pop |
| outValid | output | 1 | One-cycle pulse marking dataOut after a pop |
| full | output | 1 | All storage words hold entries |
| empty | output | 1 | No entries held |
| errFlag | output | 1 | Sticky overflow or underflow indication |

## Verification
The main stimulus is a set of reverse Polish sequences:

- a nested multiply-then-add that must give 42, which exercises operand order and stack depth beyond two;
- an addition that wraps to 1 and a product that wraps to 0, which exercise truncation;
- plain push/pop pairs that separate LIFO order from FIFO order.

Directed runs cover the remaining cases. The stack is filled to its limit and then one more word is pushed; draining it afterwards shows the refused word never landed. Pops and operators are issued on empty and one-entry stacks. A push is issued during the busy window, and the final contents show it was dropped.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_ADD  = 2'd2,
    OP_MULT = 2'd3
  } stackOp_t;

  typedef struct packed {
    logic doPush;   // push cmdData
    logic doPop;    // pop to dataOut
    logic latchA;   // pop first operand
    logic latchB;   // pop second operand
    logic pushRes;  // push arithmetic result
    logic isMult;   // result selector
    logic setErr;   // command refused
  } ctrlStrobes_t;
endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmdValid,
  input  logic [1:0]   cmdOp,
  input  logic         full,
  input  logic         empty,
  input  logic         twoAvail,
  output ctrlStrobes_t strb,
  output logic         busy
);
  typedef enum logic [1:0] {S_IDLE, S_POPA, S_POPB, S_WRB} ctrlState_t;

  ctrlState_t state, stateNext;
  logic       multReg, multNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    multNext  = multReg;
    strb.isMult = multReg;
    case (state)
      S_IDLE: begin
        if (cmdValid) begin
          case (stackOp_t'(cmdOp))
            OP_PUSH: if (full) strb.setErr = 1'b1; else strb.doPush = 1'b1;
            OP_POP:  if (empty) strb.setErr = 1'b1; else strb.doPop = 1'b1;
            default: begin
              if (!twoAvail) strb.setErr = 1'b1;
              else begin
                stateNext = S_POPA;
                multNext  = (cmdOp == OP_MULT);
              end
            end
          endcase
        end
      end
      S_POPA: begin strb.latchA  = 1'b1; stateNext = S_POPB; end
      S_POPB: begin strb.latchB  = 1'b1; stateNext = S_WRB;  end
      default: begin strb.pushRes = 1'b1; stateNext = S_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      multReg <= 1'b0;
    end else begin
      state   <= stateNext;
      multReg <= multNext;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/stack_dp.sv
module stack_dp
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 11,
  parameter int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] cmdData,
  output logic [DATA_W-1:0] dataOut,
  output logic              outValid,
  output logic              full,
  output logic              empty,
  output logic              twoAvail,
  output logic              errFlag
);
  localparam logic [PTR_W-1:0] SP_INIT = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] SP_TWO  = PTR_W'(DEPTH - 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  sp, spDown, spUp;
  logic [DATA_W-1:0] opA, opB, aluRes, wrWord, rdWord;
  logic              anyPush, anyPop;

  assign spDown  = sp - 1'b1;
  assign spUp    = sp + 1'b1;
  assign anyPush = strb.doPush | strb.pushRes;
  assign anyPop  = strb.doPop | strb.latchA | strb.latchB;
  assign rdWord  = mem[sp];
  assign aluRes  = strb.isMult ? DATA_W'(opA * opB) : DATA_W'(opA + opB);
  assign wrWord  = strb.pushRes ? aluRes : cmdData;
  assign twoAvail = (sp <= SP_TWO);

  always_ff @(posedge clk) begin
    if (anyPush) mem[spDown] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp       <= SP_INIT;
      full     <= 1'b0;
      empty    <= 1'b1;
      errFlag  <= 1'b0;
      outValid <= 1'b0;
      dataOut  <= '0;
      opA      <= '0;
      opB      <= '0;
    end else begin
      outValid <= strb.doPop;
      if (strb.setErr) errFlag <= 1'b1;
      if (anyPush) begin
        sp    <= spDown;
        full  <= (spDown == '0);
        empty <= 1'b0;
      end else if (anyPop) begin
        sp    <= spUp;
        empty <= (spUp == SP_INIT);
        full  <= 1'b0;
      end
      if (strb.doPop)  dataOut <= rdWord;
      if (strb.latchA) opA <= rdWord;
      if (strb.latchB) opB <= rdWord;
    end
  end
endmodule

// File: rtl/stack_eval.sv
module stack_eval
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  output logic              busy,
  output logic [DATA_W-1:0] dataOut,
  output logic              outValid,
  output logic              full,
  output logic              empty,
  output logic              errFlag
);
  ctrlStrobes_t strb;
  logic         twoAvail;

  stack_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .full(full), .empty(empty), .twoAvail(twoAvail),
    .strb(strb), .busy(busy)
  );

  stack_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cmdData(cmdData),
    .dataOut(dataOut), .outValid(outValid), .full(full), .empty(empty),
    .twoAvail(twoAvail), .errFlag(errFlag)
  );
endmodule

// File: rtl/stack_eval_chk.sv
module stack_eval_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic              busy,
  input logic              outValid,
  input logic              full,
  input logic              empty,
  input logic              errFlag
);
  logic [2:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rst_n) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  // R3
  no_fullempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busyRun <= 3'd3);

  // R2
  outvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(cmdValid && cmdOp == 2'd1 && !busy));

  // R7
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && cmdValid && !busy && cmdOp == 2'd0) |=> (full && errFlag));

  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && cmdValid && !busy && cmdOp != 2'd0) |=> (empty && errFlag && !outValid && !busy));
endmodule

bind stack_eval stack_eval_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .busy(busy), .outValid(outValid), .full(full), .empty(empty),
  .errFlag(errFlag)
);

// File: tb/sim_stack_eval.sv
module sim_stack_eval;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 11;
  localparam int NVEC   = 26;

  // {op[1:0], data[15:0], expected pop value[15:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 16'd3, 16'd0}, {2'd0, 16'd4, 16'd0}, {2'd3, 16'd0, 16'd0},
    {2'd0, 16'd5, 16'd0}, {2'd0, 16'd6, 16'd0}, {2'd3, 16'd0, 16'd0},
    {2'd2, 16'd0, 16'd0}, {2'd1, 16'd0, 16'd42},
    {2'd0, 16'hFFFF, 16'd0}, {2'd0, 16'd2, 16'd0}, {2'd2, 16'd0, 16'd0},
    {2'd1, 16'd0, 16'd1},
    {2'd0, 16'h0100, 16'd0}, {2'd0, 16'h0100, 16'd0}, {2'd3, 16'd0, 16'd0},
    {2'd1, 16'd0, 16'd0},
    {2'd0, 16'd7, 16'd0}, {2'd0, 16'd9, 16'd0}, {2'd1, 16'd0, 16'd9},
    {2'd1, 16'd0, 16'd7},
    {2'd0, 16'd10, 16'd0}, {2'd0, 16'd3, 16'd0}, {2'd2, 16'd0, 16'd0},
    {2'd0, 16'd2, 16'd0}, {2'd3, 16'd0, 16'd0}, {2'd1, 16'd0, 16'd26}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmdValid = 1'b0;
  logic [1:0]        cmdOp = '0;
  logic [DATA_W-1:0] cmdData = '0;
  logic              busy, outValid, full, empty, errFlag;
  logic [DATA_W-1:0] dataOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stack_eval #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .busy(busy), .dataOut(dataOut), .outValid(outValid),
    .full(full), .empty(empty), .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    cmdValid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drives a command for one edge; returns at the negedge after it.
  task automatic issue(input logic [1:0] op, input logic [DATA_W-1:0] d);
    cmdOp = op;
    cmdData = d;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic popCheck(input logic [DATA_W-1:0] exp, input string req);
    issue(2'd1, '0);
    check(outValid === 1'b1, req, int'(outValid), 1);
    check(dataOut === exp, req, int'(dataOut), int'(exp));
  endtask

  // Add or multiply: busy high for three cycles after acceptance.
  task automatic opCheck(input logic [1:0] op, input string req);
    issue(op, '0);
    check(busy === 1'b1, req, int'(busy), 1);
    repeat (2) @(negedge clk);
    check(busy === 1'b1, req, int'(busy), 1);
    @(negedge clk);
    check(busy === 1'b0, req, int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    check(empty === 1'b1, "R1", int'(empty), 1);
    check(full === 1'b0, "R1", int'(full), 0);
    check(errFlag === 1'b0, "R1", int'(errFlag), 0);
    check(busy === 1'b0 && outValid === 1'b0, "R1", int'(busy), 0);

    // Vector table: RPN sequences (R2, R5, R6)
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][33:32])
        2'd0: issue(2'd0, VEC[i][31:16]);
        2'd1: popCheck(VEC[i][15:0], "R2/R5/R6 vector");
        2'd2: opCheck(2'd2, "R5");
        default: opCheck(2'd3, "R6");
      endcase
    end
    check(empty === 1'b1 && errFlag === 1'b0, "R4", int'(empty), 1);

    // R3 / R7: fill, overflow push, drain
    for (int i = 0; i < DEPTH; i++) begin
      issue(2'd0, DATA_W'(i * 5 + 1));
      if (i == DEPTH - 2) check(full === 1'b0, "R3", int'(full), 0);
      if (i == 0) check(empty === 1'b0, "R4", int'(empty), 0);
    end
    check(full === 1'b1, "R3", int'(full), 1);
    issue(2'd0, 16'd999);
    check(errFlag === 1'b1 && full === 1'b1, "R7", int'(errFlag), 1);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      popCheck(DATA_W'(i * 5 + 1), "R7 contents");
      if (i == DEPTH - 1) check(full === 1'b0, "R3", int'(full), 0);
      if (i == 1) check(empty === 1'b0, "R4", int'(empty), 0);
    end
    check(empty === 1'b1, "R4", int'(empty), 1);

    // R8: pop on empty
    doReset();
    issue(2'd1, '0);
    check(errFlag === 1'b1 && outValid === 1'b0 && empty === 1'b1, "R8", int'(errFlag), 1);

    // R8: operator with one entry
    doReset();
    issue(2'd0, 16'd5);
    issue(2'd2, '0);
    check(busy === 1'b0 && errFlag === 1'b1, "R8", int'(busy), 0);
    // R10: later accepted commands leave the error set
    issue(2'd0, 16'd8);
    check(errFlag === 1'b1, "R10", int'(errFlag), 1);
    popCheck(16'd8, "R8");
    popCheck(16'd5, "R8");
    check(errFlag === 1'b1 && empty === 1'b1, "R10", int'(errFlag), 1);

    // R9: push during busy ignored
    doReset();
    issue(2'd0, 16'd2);
    issue(2'd0, 16'd3);
    issue(2'd2, '0);
    issue(2'd0, 16'd100);
    repeat (2) @(negedge clk);
    check(busy === 1'b0, "R9", int'(busy), 0);
    popCheck(16'd5, "R9");
    check(empty === 1'b1 && errFlag === 1'b0, "R9", int'(empty), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule